// File: doc/BRIEF.md
# Switchable-Depth Byte Queue for a Serial Channel

This block is a byte queue for one direction of a serial channel: a receiver's holding queue or a transmitter's staging queue. It always has sixteen byte slots. A single mode bit sets how many of them may be used. When the bit is clear, the queue reports full at eight entries. When the bit is set, it reports full at sixteen. The mode bit lives in a small configuration register inside this block and resets to the small setting. Its value is driven out on `shared_mode` so that the other queues of the device (the other direction, the other channel) follow the same setting at the same moment.

Bytes enter through a valid/ready port. A byte is taken on a cycle where `in_valid` and `in_ready` are both high. `in_ready` is low exactly while the queue reports full, and a byte offered then is dropped, not held. Bytes leave through a valid/ready port that shows the oldest byte ahead of the read. `out_valid` is high whenever something is stored, and a byte is removed on a cycle where `out_valid` and `out_ready` are both high. A producer that must not lose data keeps `in_valid` and `in_data` steady until it sees `in_ready`. The consumer may drop `out_ready` at any time. The queue also reports its occupancy and raises a level interrupt once it is half of the selected capacity or fuller, so the interrupt point moves with the mode.

Top module: `cfifo_top`

## Requirements
- R1: After reset, count is 0, empty is 1, full is 0, fill_irq is 0, shared_mode is 0 (capacity 8), in_ready is 1 and out_valid is 0.
- R2: A cycle with cfg_we high loads cfg_mode into the mode bit, which appears on shared_mode on the next cycle. It holds its value until the next such write. Mode 0 selects a usable capacity of 8 entries and mode 1 selects 16.
- R3: full is 1 when count is greater than or equal to the selected capacity, and in_ready is its inverse. A byte offered while full is ignored, and count never exceeds 16.
- R4: Bytes leave in the order they were accepted. out_valid equals not empty, and out_data shows the oldest stored byte before it is read.
- R5: A cycle that both accepts a byte and removes one, with the queue neither empty nor full, leaves count unchanged.
- R6: fill_irq is 1 when count is at least half the selected capacity: 4 entries in mode 0 and 8 entries in mode 1.
- R7: Switching from mode 1 to mode 0 while more than 8 bytes are stored keeps all of them. full stays 1 until count drops below 8.
- R8: A read attempt while empty changes neither count nor the read position, and out_data keeps showing the last byte that was removed.
- R9: count updates one cycle after each accepted byte (+1) or removed byte (-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load the mode bit from cfg_mode |
| cfg_mode | input | 1 | New mode value: 0 = 8 entries, 1 = 16 entries |
| shared_mode | output | 1 | Current mode bit, for the other queues of the device |
| in_valid | input | 1 | A byte is offered |
| in_ready | output | 1 | The queue can take a byte (not full) |
| in_data | input | 8 | Offered byte |
| out_valid | output | 1 | A byte is available (not empty) |
| out_ready | input | 1 | The consumer takes the shown byte |
| out_data | output | 8 | Oldest byte, or the last byte removed while empty |
| full | output | 1 | Occupancy has reached the selected capacity |
| empty | output | 1 | Nothing is stored |
| count | output | 5 | Occupancy, 0 to 16 |
| fill_irq | output | 1 | Occupancy is at least half of the selected capacity |

## Verification
The hardest state to reach is an over-full queue: more than eight bytes stored while the small capacity is selected. The ports only allow it in one order. The stimulus selects the large capacity, pushes twelve bytes, and then writes the mode bit back to zero. It then reads one byte at a time, checking that full stays set through count 8 and drops at 7, and that all twelve bytes come out in order. Reads attempted while empty are issued right after a full drain, so that the byte still held on the output is a known value.

// File: rtl/cfifo_pkg.sv
package cfifo_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned PHYS_DEPTH = 16;

  typedef enum logic {
    CAP_SMALL = 1'b0,
    CAP_LARGE = 1'b1
  } cap_mode_e;
endpackage

// File: rtl/cfifo_mode_reg.sv
module cfifo_mode_reg
  import cfifo_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic we,
  input  logic wdata,
  output logic large_sel
);
  cap_mode_e mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= CAP_SMALL;
    else if (we) mode_q <= wdata ? CAP_LARGE : CAP_SMALL;
  end

  assign large_sel = (mode_q == CAP_LARGE);

  p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> large_sel == $past(large_sel));
endmodule

// File: rtl/cfifo_store.sv
module cfifo_store #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] head,
  output logic [DATA_W-1:0] last_out
);
  logic [DATA_W-1:0] slot [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) slot[i] <= '0;
      else if (wr_en && (wr_addr == AW'(i))) slot[i] <= wr_data;
    end
  end

  assign head = slot[rd_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) last_out <= '0;
    else if (rd_en) last_out <= head;
  end

  p_last_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> last_out == $past(last_out));
endmodule

// File: rtl/cfifo_ptrs.sv
module cfifo_ptrs #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic          pop_req,
  input  logic          full,
  input  logic          empty,
  output logic          push,
  output logic          pop,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [CW-1:0] count
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [CW-1:0] count_d;

  assign push = push_req && !full;
  assign pop  = pop_req && !empty;

  always_comb begin
    count_d = count;
    if (push && !pop) count_d = count + CW'(1);
    else if (pop && !push) count_d = count - CW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + AW'(1);
      if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + AW'(1);
      count <= count_d;
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  p_full_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push_req && !pop_req) |=> count == $past(count));
  p_pair_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && pop_req && !full && !empty) |=> count == $past(count));
  p_empty_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !push_req) |=> (count == '0 && rd_ptr == $past(rd_ptr)));
endmodule

// File: rtl/cfifo_level.sv
module cfifo_level #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW   = $clog2(DEPTH) + 1,
  localparam int unsigned HALF = DEPTH / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          large_sel,
  input  logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          fill_irq
);
  logic [CW-1:0] cap;
  logic [CW-1:0] thresh;

  assign cap      = large_sel ? CW'(DEPTH) : CW'(HALF);
  assign thresh   = cap >> 1;
  assign full     = (count >= cap);
  assign empty    = (count == '0);
  assign fill_irq = (count >= thresh);

  p_irq_when_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> fill_irq);
  p_not_both_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
endmodule

// File: rtl/cfifo_top.sv
module cfifo_top
  import cfifo_pkg::*;
#(
  parameter int unsigned DATA_W = BYTE_W,
  parameter int unsigned DEPTH  = PHYS_DEPTH,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned CW    = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_mode,
  output logic              shared_mode,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              full,
  output logic              empty,
  output logic [CW-1:0]     count,
  output logic              fill_irq
);
  logic          push, pop;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [DATA_W-1:0] head, last_out;

  cfifo_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_mode), .large_sel(shared_mode)
  );

  cfifo_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .push_req(in_valid), .pop_req(out_ready),
    .full(full), .empty(empty), .push(push), .pop(pop),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .count(count)
  );

  cfifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(push), .wr_addr(wr_ptr), .wr_data(in_data),
    .rd_en(pop), .rd_addr(rd_ptr), .head(head), .last_out(last_out)
  );

  cfifo_level #(.DEPTH(DEPTH)) u_level (
    .clk(clk), .rst_n(rst_n), .large_sel(shared_mode), .count(count),
    .full(full), .empty(empty), .fill_irq(fill_irq)
  );

  assign in_ready  = !full;
  assign out_valid = !empty;
  assign out_data  = empty ? last_out : head;

  p_small_cap_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!shared_mode && count >= CW'(DEPTH / 2)) |-> !in_ready);
  p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !out_ready) |=> count == $past(count));
endmodule

// File: tb/cfifo_top_test.sv
module cfifo_top_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_mode = 1'b0;
  logic shared_mode;
  logic in_valid = 1'b0, in_ready;
  logic [7:0] in_data = '0;
  logic out_valid, out_ready = 1'b0;
  logic [7:0] out_data;
  logic full, empty, fill_irq;
  logic [4:0] count;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  cfifo_top uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .shared_mode(shared_mode), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .full(full), .empty(empty), .count(count),
    .fill_irq(fill_irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cycle(input logic iv, input logic [7:0] d, input logic ordy);
    in_valid = iv; in_data = d; out_ready = ordy;
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b0;
  endtask

  task automatic set_mode(input logic m);
    cfg_we = 1'b1; cfg_mode = m;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pop_expect(input string tag, input logic [7:0] e);
    chk({tag, " out_data"}, int'(out_data), int'(e));
    cycle(1'b0, 8'h00, 1'b1);
  endtask

  task automatic t_reset();
    chk("R1 count", int'(count), 0);
    chk("R1 empty", int'(empty), 1);
    chk("R1 full", int'(full), 0);
    chk("R1 irq", int'(fill_irq), 0);
    chk("R1 mode", int'(shared_mode), 0);
    chk("R1 in_ready", int'(in_ready), 1);
    chk("R1 out_valid", int'(out_valid), 0);
  endtask

  task automatic t_cap8();
    for (int i = 0; i < 3; i++) cycle(1'b1, 8'h10 + 8'(i), 1'b0);
    chk("R9 count after 3", int'(count), 3);
    chk("R6 irq below 4", int'(fill_irq), 0);
    cycle(1'b1, 8'h13, 1'b0);
    chk("R6 irq at 4", int'(fill_irq), 1);
    for (int i = 4; i < 7; i++) cycle(1'b1, 8'h10 + 8'(i), 1'b0);
    chk("R3 not full at 7", int'(full), 0);
    cycle(1'b1, 8'h17, 1'b0);
    chk("R3 full at 8", int'(full), 1);
    chk("R3 in_ready at 8", int'(in_ready), 0);
    cycle(1'b1, 8'hEE, 1'b0);
    cycle(1'b1, 8'hEE, 1'b0);
    chk("R3 write ignored", int'(count), 8);
    chk("R4 out_valid", int'(out_valid), 1);
    for (int i = 0; i < 8; i++) pop_expect("R4 order8", 8'h10 + 8'(i));
    chk("R9 count drained", int'(count), 0);
    chk("R4 empty", int'(empty), 1);
  endtask

  task automatic t_empty_pop();
    cycle(1'b0, 8'h00, 1'b1);
    cycle(1'b0, 8'h00, 1'b1);
    chk("R8 count", int'(count), 0);
    chk("R8 out_data held", int'(out_data), 8'h17);
    cycle(1'b1, 8'h55, 1'b0);
    cycle(1'b1, 8'h56, 1'b0);
    chk("R9 count 2", int'(count), 2);
    pop_expect("R8 pointer kept", 8'h55);
    pop_expect("R8 pointer kept", 8'h56);
    chk("R8 out_data last", int'(out_data), 8'h56);
  endtask

  task automatic t_cap16();
    set_mode(1'b1);
    chk("R2 mode set", int'(shared_mode), 1);
    for (int i = 0; i < 7; i++) cycle(1'b1, 8'h20 + 8'(i), 1'b0);
    chk("R6 irq at 7 large", int'(fill_irq), 0);
    cycle(1'b1, 8'h27, 1'b0);
    chk("R6 irq at 8 large", int'(fill_irq), 1);
    chk("R2 not full at 8 large", int'(full), 0);
    for (int i = 8; i < 15; i++) cycle(1'b1, 8'h20 + 8'(i), 1'b0);
    chk("R3 not full at 15", int'(full), 0);
    cycle(1'b1, 8'h2F, 1'b0);
    chk("R3 full at 16", int'(full), 1);
    cycle(1'b1, 8'hEE, 1'b0);
    chk("R3 count capped 16", int'(count), 16);
    for (int i = 0; i < 16; i++) pop_expect("R4 order16", 8'h20 + 8'(i));
    chk("R2 mode held", int'(shared_mode), 1);
  endtask

  task automatic t_pair();
    for (int i = 0; i < 3; i++) cycle(1'b1, 8'h30 + 8'(i), 1'b0);
    cycle(1'b1, 8'h33, 1'b1);
    chk("R5 count unchanged", int'(count), 3);
    pop_expect("R5 order", 8'h31);
    pop_expect("R5 order", 8'h32);
    pop_expect("R5 order", 8'h33);
    chk("R5 empty", int'(empty), 1);
  endtask

  task automatic t_shrink();
    for (int i = 0; i < 12; i++) cycle(1'b1, 8'h40 + 8'(i), 1'b0);
    set_mode(1'b0);
    chk("R2 mode cleared", int'(shared_mode), 0);
    chk("R7 count kept", int'(count), 12);
    chk("R7 full", int'(full), 1);
    cycle(1'b1, 8'h99, 1'b0);
    chk("R7 write ignored", int'(count), 12);
    for (int i = 0; i < 4; i++) pop_expect("R7 order", 8'h40 + 8'(i));
    chk("R7 count 8", int'(count), 8);
    chk("R7 full at 8", int'(full), 1);
    pop_expect("R7 order", 8'h44);
    chk("R7 full clear at 7", int'(full), 0);
    chk("R7 in_ready at 7", int'(in_ready), 1);
    for (int i = 5; i < 12; i++) pop_expect("R7 order", 8'h40 + 8'(i));
    chk("R7 empty", int'(empty), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cap8();
    t_empty_pop();
    t_cap16();
    t_pair();
    t_shrink();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule